// File: doc/BRIEF.md
# Multi-Ring Periodic Timer Scheduler

This block keeps a set of independent timer rings that share one free-running prescaler. Every ring has its own period, its own ring of buckets in memory (a base pointer and a bucket count), and a time offset. The offset counts down once per prescaler tick. When a ring's period runs out, the ring raises a bucket-traversal request. The request names the ring and the memory address of that ring's current bucket. The ring then moves on to its next bucket, wrapping around circularly.

Requests from all rings pass through a round-robin arbiter and go out one at a time on a valid/done handshake. A downstream engine walks the bucket and then pulses done. A global run input stops the prescaler and holds back new grants. Requests that are already queued wait until the run input returns. A ring whose period elapses again before its previous request was completed sets a sticky error bit. Error bits are cleared by writing ones. A masked OR of the error bits drives an interrupt line.

Top module: `ring_timer_sched`

## Requirements
- R1: After reset, trav_req, err_mask and irq are all zero.
- R2: With the run input high and requests served promptly, a ring whose period field is V issues requests exactly (V+1)*TICK_DIV clock cycles apart.
- R3: trav_ring carries the requesting ring's number. trav_addr equals {base, 5'b0} + index*2^BKT_SHIFT, where the bucket stride is 32 bytes by default.
- R4: A ring's bucket index starts at 0 and advances by one per granted request. After the value held in the bucket-count field (buckets minus one), it wraps to 0.
- R5: A write to a ring's geometry (base/count) sets that ring's bucket index back to 0.
- R6: Rings that are pending at the same time are granted in ascending ring order, starting just after the most recently granted ring and wrapping. After reset, the search starts at ring 0.
- R7: Only one request is outstanding at a time. trav_req, trav_ring and trav_addr hold steady until trav_done is seen.
- R8: While glb_en is low, no new request is granted and queued requests stay queued. An outstanding request still completes. When glb_en returns high, the queued request is granted on the next clock edge.
- R9: Clearing a ring's enable bit stops new requests from that ring, but a request already queued for it is still issued.
- R10: If a ring's period elapses while that ring already has a queued or outstanding request, error bit [ring] is set one cycle later.
- R11: A clear strobe removes the error bits whose clear-data bit is 1 and leaves every other error bit unchanged.
- R12: irq is high one cycle after any bit is set in both err_mask and irq_en. An error bit whose irq_en bit is 0 does not raise irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Global run: prescaler and grants |
| cfg_wr_time | input | 1 | Write strobe for period and ring enable; reloads the offset |
| cfg_wr_geom | input | 1 | Write strobe for base and bucket count; clears the index |
| cfg_ring | input | 4 | Ring addressed by a configuration write |
| cfg_ival | input | 22 | Period in ticks, minus one |
| cfg_en | input | 1 | Ring enable |
| cfg_base | input | 31 | Base address bits [35:5] |
| cfg_nbkt | input | 20 | Number of buckets minus one |
| trav_req | output | 1 | Traversal request valid |
| trav_ring | output | 4 | Ring of the request |
| trav_addr | output | 36 | Byte address of the bucket to walk |
| trav_done | input | 1 | Pulse: outstanding traversal complete |
| err_clr_wr | input | 1 | Error clear strobe |
| err_clr_bits | input | 16 | Ones clear the matching error bits |
| irq_en | input | 16 | Interrupt enable per ring |
| err_mask | output | 16 | Sticky per-ring overrun flags |
| irq | output | 1 | Interrupt |

## Verification
The bench measures the spacing between successive requests of one ring. A design that reloaded the offset with the period minus one, or that treated zero as the underflow point too early, would show a gap that is off by one tick. It walks a three-bucket ring past its wrap point, rewrites the geometry, and watches whether the index goes back to bucket 0. It then fires three rings on the same tick, twice, to expose an arbiter that always favours the lowest number or never wraps its pointer. It withholds done until a ring overruns, and it drops the global run while one request is outstanding and another is queued. A design that discarded queued work, or kept granting while stopped, fails there. So does one whose clear or interrupt mask touches the wrong bits.

// File: rtl/rts_pkg.sv
package rts_pkg;
  localparam int IVAL_W = 22;
  localparam int IDX_W  = 20;
  localparam int BASE_W = 31;
  localparam int ALIGN  = 5;
  localparam int ADDR_W = BASE_W + ALIGN;
endpackage

// File: rtl/rts_prescaler.sv
module rts_prescaler #(
  parameter int DIV = 1024,
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  logic [CW-1:0] cnt_q;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (run) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign tick = run && (cnt_q == LAST);

  generate
    if (DIV > 1) begin : g_chk
      assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/rts_ring_bank.sv
module rts_ring_bank import rts_pkg::*; #(
  parameter int N = 16,
  localparam int RW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        tick,
  input  logic                        wr_time,
  input  logic                        wr_geom,
  input  logic [RW-1:0]               wr_ring,
  input  logic [IVAL_W-1:0]           wr_ival,
  input  logic                        wr_en,
  input  logic [BASE_W-1:0]           wr_base,
  input  logic [IDX_W-1:0]            wr_nbkt,
  input  logic                        adv,
  input  logic [RW-1:0]               adv_ring,
  output logic [N-1:0]                uflow,
  output logic [N-1:0][BASE_W-1:0]    base_q,
  output logic [N-1:0][IDX_W-1:0]     idx_q
);
  logic [N-1:0] en_q;

  generate
    for (genvar r = 0; r < N; r++) begin : g_ring
      logic [IVAL_W-1:0] ival_q, off_q;
      logic [IDX_W-1:0]  nbkt_q;
      logic              sel;

      assign sel      = (wr_ring == RW'(r));
      assign uflow[r] = tick && en_q[r] && (off_q == '0) && !(wr_time && sel);

      always_ff @(posedge clk) begin
        if (rst) begin
          ival_q  <= '0;
          off_q   <= '0;
          en_q[r] <= 1'b0;
        end else if (wr_time && sel) begin
          ival_q  <= wr_ival;
          off_q   <= wr_ival;
          en_q[r] <= wr_en;
        end else if (tick && en_q[r]) begin
          off_q <= (off_q == '0) ? ival_q : off_q - 1'b1;
        end
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          base_q[r] <= '0;
          nbkt_q    <= '0;
          idx_q[r]  <= '0;
        end else if (wr_geom && sel) begin
          base_q[r] <= wr_base;
          nbkt_q    <= wr_nbkt;
          idx_q[r]  <= '0;
        end else if (adv && adv_ring == RW'(r)) begin
          idx_q[r] <= (idx_q[r] == nbkt_q) ? '0 : idx_q[r] + 1'b1;
        end
      end

      assert_idx_range_R4: assert property (@(posedge clk) disable iff (rst)
        idx_q[r] <= nbkt_q);
    end
  endgenerate
endmodule

// File: rtl/rts_rr_arb.sv
module rts_rr_arb #(
  parameter int N = 16,
  localparam int RW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [RW-1:0] last,
  output logic          any,
  output logic [RW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = last;
    for (int k = 1; k <= N; k++) begin
      if (!any && req[(int'(last) + k) % N]) begin
        any = 1'b1;
        idx = RW'((int'(last) + k) % N);
      end
    end
  end
endmodule

// File: rtl/ring_timer_sched.sv
module ring_timer_sched import rts_pkg::*; #(
  parameter int NUM_RINGS = 16,
  parameter int TICK_DIV  = 1024,
  parameter int BKT_SHIFT = 5,
  localparam int RW = (NUM_RINGS > 1) ? $clog2(NUM_RINGS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 glb_en,
  input  logic                 cfg_wr_time,
  input  logic                 cfg_wr_geom,
  input  logic [RW-1:0]        cfg_ring,
  input  logic [IVAL_W-1:0]    cfg_ival,
  input  logic                 cfg_en,
  input  logic [BASE_W-1:0]    cfg_base,
  input  logic [IDX_W-1:0]     cfg_nbkt,
  output logic                 trav_req,
  output logic [RW-1:0]        trav_ring,
  output logic [ADDR_W-1:0]    trav_addr,
  input  logic                 trav_done,
  input  logic                 err_clr_wr,
  input  logic [NUM_RINGS-1:0] err_clr_bits,
  input  logic [NUM_RINGS-1:0] irq_en,
  output logic [NUM_RINGS-1:0] err_mask,
  output logic                 irq
);
  logic                              tick;
  logic [NUM_RINGS-1:0]              uflow;
  logic [NUM_RINGS-1:0][BASE_W-1:0]  base_q;
  logic [NUM_RINGS-1:0][IDX_W-1:0]   idx_q;
  logic [NUM_RINGS-1:0]              pend_q, act_mask, gnt_mask, err_set, clr_mask;
  logic [RW-1:0]                     last_q, arb_idx;
  logic                              arb_any, grant;
  logic [ADDR_W-1:0]                 gnt_addr;

  rts_prescaler #(.DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst(rst), .run(glb_en), .tick(tick));

  rts_ring_bank #(.N(NUM_RINGS)) u_bank (
    .clk(clk), .rst(rst), .tick(tick),
    .wr_time(cfg_wr_time), .wr_geom(cfg_wr_geom), .wr_ring(cfg_ring),
    .wr_ival(cfg_ival), .wr_en(cfg_en), .wr_base(cfg_base), .wr_nbkt(cfg_nbkt),
    .adv(grant), .adv_ring(arb_idx),
    .uflow(uflow), .base_q(base_q), .idx_q(idx_q));

  rts_rr_arb #(.N(NUM_RINGS)) u_arb (
    .req(pend_q), .last(last_q), .any(arb_any), .idx(arb_idx));

  assign grant    = !trav_req && glb_en && arb_any;
  assign gnt_addr = {base_q[arb_idx], {ALIGN{1'b0}}}
                  + (ADDR_W'(idx_q[arb_idx]) << BKT_SHIFT);

  always_comb begin
    for (int r = 0; r < NUM_RINGS; r++) begin
      act_mask[r] = trav_req && (trav_ring == RW'(r));
      gnt_mask[r] = grant && (arb_idx == RW'(r));
    end
    err_set  = uflow & (pend_q | act_mask);
    clr_mask = err_clr_wr ? err_clr_bits : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= '0;
      last_q    <= RW'(NUM_RINGS - 1);
      trav_req  <= 1'b0;
      trav_ring <= '0;
      trav_addr <= '0;
      err_mask  <= '0;
      irq       <= 1'b0;
    end else begin
      pend_q   <= (pend_q & ~gnt_mask) | uflow;
      err_mask <= (err_mask & ~clr_mask) | err_set;
      irq      <= |(err_mask & irq_en);
      if (grant) begin
        trav_req  <= 1'b1;
        trav_ring <= arb_idx;
        trav_addr <= gnt_addr;
        last_q    <= arb_idx;
      end else if (trav_req && trav_done) begin
        trav_req <= 1'b0;
      end
    end
  end

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (rst)
    trav_req && !trav_done |=> trav_req && $stable(trav_ring) && $stable(trav_addr));

  assert_no_grant_stopped_R8: assert property (@(posedge clk) disable iff (rst)
    !glb_en && !trav_req |=> !trav_req);

  assert_err_on_tick_R10: assert property (@(posedge clk) disable iff (rst)
    (|(err_mask & ~$past(err_mask))) |-> $past(tick));

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    ($past(err_mask) & ~$past(clr_mask) & ~err_mask) == '0);
endmodule

// File: tb/sim_ring_timer_sched.sv
module sim_ring_timer_sched;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 8;
  localparam int NR = 16;

  logic clk = 0, rst = 1, glb_en = 0;
  logic cfg_wr_time = 0, cfg_wr_geom = 0, cfg_en = 0;
  logic [3:0] cfg_ring = 0;
  logic [21:0] cfg_ival = 0;
  logic [30:0] cfg_base = 0;
  logic [19:0] cfg_nbkt = 0;
  logic trav_req, trav_done = 0, irq;
  logic [3:0] trav_ring;
  logic [35:0] trav_addr;
  logic err_clr_wr = 0;
  logic [NR-1:0] err_clr_bits = 0, irq_en = 0, err_mask;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  ring_timer_sched #(.NUM_RINGS(NR), .TICK_DIV(DIV), .BKT_SHIFT(5)) u0 (
    .clk(clk), .rst(rst), .glb_en(glb_en),
    .cfg_wr_time(cfg_wr_time), .cfg_wr_geom(cfg_wr_geom), .cfg_ring(cfg_ring),
    .cfg_ival(cfg_ival), .cfg_en(cfg_en), .cfg_base(cfg_base), .cfg_nbkt(cfg_nbkt),
    .trav_req(trav_req), .trav_ring(trav_ring), .trav_addr(trav_addr),
    .trav_done(trav_done), .err_clr_wr(err_clr_wr), .err_clr_bits(err_clr_bits),
    .irq_en(irq_en), .err_mask(err_mask), .irq(irq));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; glb_en = 0; trav_done = 0; err_clr_wr = 0; irq_en = 0;
    cfg_wr_time = 0; cfg_wr_geom = 0;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic cfg_time(input int r, input int iv, input bit en);
    @(negedge clk);
    cfg_wr_time = 1; cfg_ring = 4'(r); cfg_ival = 22'(iv); cfg_en = en;
    @(negedge clk);
    cfg_wr_time = 0;
  endtask

  task automatic cfg_geom(input int r, input int base, input int nb);
    @(negedge clk);
    cfg_wr_geom = 1; cfg_ring = 4'(r); cfg_base = 31'(base); cfg_nbkt = 20'(nb);
    @(negedge clk);
    cfg_wr_geom = 0;
  endtask

  task automatic wait_req(input string tag, output int t);
    t = -1;
    for (int i = 0; i < 2000; i++) begin
      if (trav_req) begin t = cyc; break; end
      @(negedge clk);
    end
    if (t < 0) chk(0, {tag, " request timeout"}, 0, 1);
  endtask

  task automatic serve();
    @(negedge clk) trav_done = 1;
    @(negedge clk) trav_done = 0;
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk(trav_req == 0, "R1 trav_req", trav_req, 0);
    chk(err_mask == 0, "R1 err_mask", err_mask, 0);
    chk(irq == 0, "R1 irq", irq, 0);
  endtask

  task automatic t_period_addr();
    int t0, t1;
    logic [35:0] exp_a [4] = '{36'h2000, 36'h2020, 36'h2040, 36'h2000};
    do_reset();
    glb_en = 1;
    cfg_geom(3, 'h100, 2);
    cfg_time(3, 2, 1);
    t0 = 0;
    for (int k = 0; k < 4; k++) begin
      wait_req("R2", t1);
      chk(trav_ring == 3, "R3 ring id", trav_ring, 3);
      chk(trav_addr == exp_a[k], "R3 R4 bucket address", trav_addr, exp_a[k]);
      if (k > 0) chk(t1 - t0 == 3*DIV, "R2 spacing", t1 - t0, 3*DIV);
      t0 = t1;
      serve();
    end
    cfg_time(3, 2, 0);
    cfg_geom(3, 'h200, 2);
    cfg_time(3, 2, 1);
    wait_req("R5", t1);
    chk(trav_addr == 36'h4000, "R5 index cleared by geometry write", trav_addr, 36'h4000);
    serve();
    glb_en = 0;
  endtask

  task automatic t_round_robin();
    int t;
    int order [3] = '{1, 2, 5};
    do_reset();
    cfg_time(1, 3, 1); cfg_time(2, 3, 1); cfg_time(5, 3, 1);
    glb_en = 1;
    for (int rnd = 0; rnd < 2; rnd++) begin
      for (int k = 0; k < 3; k++) begin
        wait_req("R6", t);
        chk(trav_ring == 4'(order[k]), "R6 grant order", trav_ring, order[k]);
        serve();
      end
    end
    chk(err_mask == 0, "R10 no error when served in time", err_mask, 0);
    glb_en = 0;
  endtask

  task automatic t_overrun();
    int t;
    do_reset();
    glb_en = 1;
    cfg_geom(4, 'h40, 0);
    cfg_time(4, 0, 1);
    wait_req("R10", t);
    chk(err_mask == 0, "R10 first period no error", err_mask, 0);
    repeat (3*DIV) @(negedge clk);
    chk(trav_req == 1 && trav_ring == 4 && trav_addr == 36'h800, "R7 held request",
        {trav_req, trav_ring, trav_addr}, {1'b1, 4'h4, 36'h800});
    chk(err_mask == 16'h0010, "R10 overrun flagged", err_mask, 16'h0010);
    chk(irq == 0, "R12 masked irq", irq, 0);
    irq_en = 16'h0010;
    repeat (2) @(negedge clk);
    chk(irq == 1, "R12 enabled irq", irq, 1);
    cfg_time(4, 0, 0);
    @(negedge clk) begin err_clr_wr = 1; err_clr_bits = 16'hFFEF; end
    @(negedge clk) err_clr_wr = 0;
    chk(err_mask == 16'h0010, "R11 other bits leave flag", err_mask, 16'h0010);
    serve();
    repeat (3) @(negedge clk);
    if (trav_req) serve();
    repeat (2) @(negedge clk);
    @(negedge clk) begin err_clr_wr = 1; err_clr_bits = 16'h0010; end
    @(negedge clk) err_clr_wr = 0;
    chk(err_mask == 0, "R11 flag cleared", err_mask, 0);
    repeat (2) @(negedge clk);
    chk(irq == 0, "R12 irq drops", irq, 0);
    glb_en = 0;
  endtask

  task automatic t_global_stop();
    int t;
    bit leaked = 0;
    do_reset();
    cfg_time(6, 1, 1); cfg_time(7, 1, 1);
    glb_en = 1;
    wait_req("R8", t);
    chk(trav_ring == 6, "R8 first ring", trav_ring, 6);
    glb_en = 0;
    serve();
    chk(trav_req == 0, "R8 active request completes", trav_req, 0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (trav_req) leaked = 1;
    end
    chk(!leaked, "R8 no grant while stopped", leaked, 0);
    glb_en = 1;
    t = cyc;
    @(negedge clk);
    chk(trav_req == 1 && trav_ring == 7, "R8 queued request resumes",
        {trav_req, trav_ring}, {1'b1, 4'h7});
    serve();
    glb_en = 0;
    repeat (2) @(negedge clk);
    if (trav_req) serve();
  endtask

  task automatic t_ring_disable();
    int t;
    bit bad = 0;
    do_reset();
    cfg_time(8, 0, 1); cfg_time(9, 0, 1);
    glb_en = 1;
    wait_req("R9", t);
    chk(trav_ring == 8, "R9 first ring", trav_ring, 8);
    cfg_time(9, 0, 0);
    serve();
    wait_req("R9", t);
    chk(trav_ring == 9, "R9 queued request of disabled ring", trav_ring, 9);
    serve();
    cfg_time(8, 0, 0);
    for (int i = 0; i < 10*DIV; i++) begin
      @(negedge clk);
      if (trav_req) begin
        if (trav_ring == 9) bad = 1;
        serve();
      end
    end
    chk(!bad, "R9 no new request after disable", bad, 0);
    glb_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    report();
  end

  initial begin
    t_reset();
    t_period_addr();
    t_round_robin();
    t_overrun();
    t_global_stop();
    t_ring_disable();
    report();
  end
endmodule